// File: doc/BRIEF.md
# Gated Lock Actuator Drive Sequencer

This block drives one lock actuator through an H-bridge style output made of an enable, a direction and a PWM signal. The driver enable stays low until an authorization pulse arrives while every interlock input is true, the supply is not flagged low, and the door and bolt sensors show the expected starting position. Only then does a run begin. During the run the block watches four things: a stream of digitized current samples, an end-stop input, the low-voltage flag and the interlocks. It ends the run on the first condition that settles the outcome.

Each finished attempt produces a one-cycle done pulse with a 4-bit result code, the count of consecutive jams, and the run time in milliseconds, so that a logger can record the attempt. A jam counts toward a retry budget. When the budget is used up, the block refuses all motion until an explicit clear input releases it. The authorization decision, the current-sense front end and the converter are outside this block and appear only as inputs.

Result codes: 0 none, 1 success, 2 soft jam (recoverable friction), 3 hard jam, 4 timeout, 5 overcurrent, 6 low voltage, 7 position mismatch before motion, 8 position mismatch after motion, 9 interlock not satisfied, 10 locked out.

Top module: `lock_act_seq`

## Requirements
- R1: `drv_en` is 0 after reset and outside a run. It rises only on the cycle after an `auth_pulse` was sampled with all `ilk_ok` bits at 1, `low_volt` at 0 and the starting positions correct. It falls on the same edge that raises `done`.
- R2: Before motion, `door_closed` must be 1 and `bolt_ext` must equal the inverse of `move_dir` (1 means extend). If not, the result is 7 and no motion starts. When `end_stop` is seen during a run, `door_closed` must be 1 and `bolt_ext` must equal the latched direction. The result is 1 if both hold and 8 if not.
- R3: An authorization with any interlock low gives result 9, and one with `low_volt` high gives result 6, without motion. During a run, a loss of interlock ends the run with result 9 and `low_volt` ends it with result 6.
- R4: A valid current sample above `cfg_oc_th` during a run ends the run with result 5.
- R5: An `end_stop` in the same cycle as an overcurrent sample is treated as the end of travel, not as overcurrent.
- R6: Once `cfg_blank_ms` milliseconds of the run have passed, JAM_SAMPLES consecutive valid samples at or above `cfg_plat_th` mark a jam. Samples taken inside the blanking window, such as the startup peak, never count toward a jam.
- R7: When the run time reaches `cfg_timeout_ms` without another outcome, the run ends with result 4 and `run_ms` reports the timeout value.
- R8: Each jam increments `retry_cnt`. The result is 2 while the new count is below MAX_RETRY and 3 when it reaches MAX_RETRY. A success clears `retry_cnt` to 0, and all other outcomes leave it unchanged.
- R9: After a hard jam, every authorization gives result 10 with `drv_en` held low, until `clear_lockout` returns the block to idle with `retry_cnt` at 0.
- R10: `done` is a one-cycle pulse. `result`, `retry_cnt` and `run_ms` hold the values of the latest attempt.
- R11: While enabled, `drv_pwm` is high for `cfg_duty` cycles out of every PWM_PERIOD cycles, and it is 0 whenever `drv_en` is 0. `drv_dir` carries the direction latched at the start of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auth_pulse | input | 1 | One-cycle valid authorization |
| move_dir | input | 1 | Requested direction, 1 extends the bolt |
| ilk_ok | input | NUM_ILK | Interlock inputs, all must be 1 |
| low_volt | input | 1 | Supply below safe actuation level |
| door_closed | input | 1 | Door position sensor |
| bolt_ext | input | 1 | Bolt position sensor, 1 extended |
| end_stop | input | 1 | End of travel reached |
| cur_valid | input | 1 | Current sample strobe |
| cur_sample | input | CUR_W | Unsigned current sample |
| cfg_plat_th | input | CUR_W | Jam plateau threshold |
| cfg_oc_th | input | CUR_W | Overcurrent threshold |
| cfg_blank_ms | input | MS_W | Startup blanking window in ms |
| cfg_timeout_ms | input | MS_W | Run time limit in ms |
| cfg_duty | input | $clog2(PWM_PERIOD+1) | PWM high cycles per period |
| clear_lockout | input | 1 | Leave the locked-out state |
| drv_en | output | 1 | Driver enable |
| drv_dir | output | 1 | Driver direction |
| drv_pwm | output | 1 | Driver PWM |
| done | output | 1 | Attempt finished pulse |
| result | output | 4 | Result code |
| retry_cnt | output | $clog2(MAX_RETRY+1) | Consecutive jam count |
| run_ms | output | MS_W | Elapsed run time in ms |

## Verification
Runs are driven with four current shapes. The first is a peak followed by a low plateau, and it separates blanking from jam detection: it must end on the end-stop, or on a timeout when there is no end-stop. The second is a peak followed by a high plateau, and it must be reported as a jam. The third is a late spike above the overcurrent level. The fourth puts that spike in the same cycle as the end-stop, which shows that end of travel wins over overcurrent. Position sensors placed wrong before or after motion separate codes 7 and 8. Interlock and supply faults are injected both at authorization and during the run. Three jams in a row check the soft-to-hard progression, the lockout and the clear path.

// File: rtl/lock_act_pkg.sv
package lock_act_pkg;

    typedef enum logic [3:0] {
        RES_NONE     = 4'd0,
        RES_OK       = 4'd1,
        RES_JAM_SOFT = 4'd2,
        RES_JAM_HARD = 4'd3,
        RES_TIMEOUT  = 4'd4,
        RES_OVERCUR  = 4'd5,
        RES_LOWV     = 4'd6,
        RES_PRE_MIS  = 4'd7,
        RES_POST_MIS = 4'd8,
        RES_ILK      = 4'd9,
        RES_LOCKED   = 4'd10
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOCK = 2'd2
    } seq_state_e;

    // Position agreement: before motion the bolt sits opposite the target,
    // after motion it sits at the target; the door is closed in both cases.
    function automatic logic pos_ok(input logic door, input logic bolt,
                                    input logic dir, input logic after);
        return door && (bolt == (after ? dir : !dir));
    endfunction

endpackage

// File: rtl/act_ms_timer.sv
module act_ms_timer #(
    parameter int CYC_PER_MS = 200000,
    parameter int MS_W       = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            run,
    output logic [MS_W-1:0] ms
);
    localparam int CW = $clog2(CYC_PER_MS + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cyc <= '0;
            ms  <= '0;
        end else if (run) begin
            if (cyc == CYC_LAST) begin
                cyc <= '0;
                if (ms != '1) ms <= ms + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // R10
    ms_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> (ms == $past(ms)));

endmodule

// File: rtl/act_jam_det.sv
module act_jam_det #(
    parameter int CUR_W       = 10,
    parameter int JAM_SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             blank_done,
    input  logic             cur_valid,
    input  logic [CUR_W-1:0] cur,
    input  logic [CUR_W-1:0] plat_th,
    output logic             jam
);
    localparam int JW = $clog2(JAM_SAMPLES + 1);
    localparam logic [JW-1:0] JAM_N = JW'(JAM_SAMPLES);

    logic [JW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            hi_cnt <= '0;
        end else if (run && cur_valid && blank_done) begin
            if (cur < plat_th)      hi_cnt <= '0;
            else if (hi_cnt != JAM_N) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign jam = (hi_cnt == JAM_N);

    // R6
    jam_after_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!blank_done && !start) |=> (hi_cnt == $past(hi_cnt)));

endmodule

// File: rtl/act_pwm.sv
module act_pwm #(
    parameter int PWM_PERIOD = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic [$clog2(PWM_PERIOD+1)-1:0] duty,
    output logic                            pwm
);
    localparam int PW = $clog2(PWM_PERIOD + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PWM_PERIOD - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)          cnt <= '0;
        else if (cnt == P_LAST)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign pwm = en && (cnt < duty);

    // R11
    pwm_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

// File: rtl/lock_act_seq.sv
module lock_act_seq
    import lock_act_pkg::*;
#(
    parameter int NUM_ILK     = 3,
    parameter int CUR_W       = 10,
    parameter int MS_W        = 16,
    parameter int CYC_PER_MS  = 200000,
    parameter int JAM_SAMPLES = 4,
    parameter int MAX_RETRY   = 3,
    parameter int PWM_PERIOD  = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               auth_pulse,
    input  logic                               move_dir,
    input  logic [NUM_ILK-1:0]                 ilk_ok,
    input  logic                               low_volt,
    input  logic                               door_closed,
    input  logic                               bolt_ext,
    input  logic                               end_stop,
    input  logic                               cur_valid,
    input  logic [CUR_W-1:0]                   cur_sample,
    input  logic [CUR_W-1:0]                   cfg_plat_th,
    input  logic [CUR_W-1:0]                   cfg_oc_th,
    input  logic [MS_W-1:0]                    cfg_blank_ms,
    input  logic [MS_W-1:0]                    cfg_timeout_ms,
    input  logic [$clog2(PWM_PERIOD+1)-1:0]    cfg_duty,
    input  logic                               clear_lockout,
    output logic                               drv_en,
    output logic                               drv_dir,
    output logic                               drv_pwm,
    output logic                               done,
    output logic [3:0]                         result,
    output logic [$clog2(MAX_RETRY+1)-1:0]     retry_cnt,
    output logic [MS_W-1:0]                    run_ms
);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);
    localparam logic [RTY_W-1:0] RTY_MAX = RTY_W'(MAX_RETRY);

    seq_state_e state_q;
    logic       dir_q;
    logic       go;
    logic       jam;
    logic       blank_done;
    logic       ilk_all;
    logic       oc_hit;
    res_e       idle_res;
    res_e       run_res;
    logic [RTY_W-1:0] rty_next;

    assign ilk_all    = &ilk_ok;
    assign blank_done = (run_ms >= cfg_blank_ms);
    assign oc_hit     = cur_valid && (cur_sample > cfg_oc_th);
    assign rty_next   = retry_cnt + 1'b1;

    // Refusal reasons at authorization, highest priority first.
    always_comb begin
        if (!ilk_all)                                             idle_res = RES_ILK;
        else if (low_volt)                                        idle_res = RES_LOWV;
        else if (!pos_ok(door_closed, bolt_ext, move_dir, 1'b0))  idle_res = RES_PRE_MIS;
        else                                                      idle_res = RES_NONE;
    end

    assign go = (state_q == ST_IDLE) && auth_pulse && (idle_res == RES_NONE);

    // Run outcome, highest priority first; end of travel outranks overcurrent.
    always_comb begin
        if (low_volt)          run_res = RES_LOWV;
        else if (!ilk_all)     run_res = RES_ILK;
        else if (end_stop)     run_res = pos_ok(door_closed, bolt_ext, dir_q, 1'b1)
                                         ? RES_OK : RES_POST_MIS;
        else if (oc_hit)       run_res = RES_OVERCUR;
        else if (jam)          run_res = (rty_next == RTY_MAX) ? RES_JAM_HARD : RES_JAM_SOFT;
        else if (run_ms >= cfg_timeout_ms) run_res = RES_TIMEOUT;
        else                   run_res = RES_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dir_q     <= 1'b0;
            done      <= 1'b0;
            result    <= RES_NONE;
            retry_cnt <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q <= ST_RUN;
                        dir_q   <= move_dir;
                    end else if (auth_pulse) begin
                        done   <= 1'b1;
                        result <= idle_res;
                    end
                end
                ST_RUN: begin
                    if (run_res != RES_NONE) begin
                        done    <= 1'b1;
                        result  <= run_res;
                        state_q <= (run_res == RES_JAM_HARD) ? ST_LOCK : ST_IDLE;
                        if (run_res == RES_OK)
                            retry_cnt <= '0;
                        else if (run_res == RES_JAM_SOFT || run_res == RES_JAM_HARD)
                            retry_cnt <= rty_next;
                    end
                end
                ST_LOCK: begin
                    if (clear_lockout) begin
                        state_q   <= ST_IDLE;
                        retry_cnt <= '0;
                    end else if (auth_pulse) begin
                        done   <= 1'b1;
                        result <= RES_LOCKED;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign drv_en  = (state_q == ST_RUN);
    assign drv_dir = dir_q;

    act_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) i_timer (
        .clk(clk), .rst(rst), .start(go), .run(drv_en), .ms(run_ms)
    );

    act_jam_det #(.CUR_W(CUR_W), .JAM_SAMPLES(JAM_SAMPLES)) i_jam (
        .clk(clk), .rst(rst), .start(go), .run(drv_en), .blank_done(blank_done),
        .cur_valid(cur_valid), .cur(cur_sample), .plat_th(cfg_plat_th), .jam(jam)
    );

    act_pwm #(.PWM_PERIOD(PWM_PERIOD)) i_pwm (
        .clk(clk), .rst(rst), .en(drv_en), .duty(cfg_duty), .pwm(drv_pwm)
    );

    // R1
    en_after_auth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> $past(auth_pulse && (&ilk_ok) && !low_volt));

    // R1
    en_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !drv_en);

    // R4
    oc_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_en && cur_valid && (cur_sample > cfg_oc_th) && !end_stop) |=> !drv_en);

    // R7
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (run_ms <= cfg_timeout_ms));

    // R8
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        retry_cnt <= RTY_MAX);

    // R11
    pwm_gated_chk: assert property (@(posedge clk) disable iff (rst)
        drv_pwm |-> drv_en);

endmodule

// File: tb/test_lock_act_seq.sv
`timescale 1ns/1ps
module test_lock_act_seq;
    localparam int NUM_ILK = 3;
    localparam int CUR_W   = 10;
    localparam int MS_W    = 16;
    localparam int CPM     = 10;
    localparam int PER     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auth_pulse = 1'b0, move_dir = 1'b0;
    logic [NUM_ILK-1:0] ilk_ok = '1;
    logic low_volt = 1'b0, door_closed = 1'b1, bolt_ext = 1'b0, end_stop = 1'b0;
    logic cur_valid = 1'b0;
    logic [CUR_W-1:0] cur_sample = '0;
    logic [CUR_W-1:0] cfg_plat_th = 10'd100, cfg_oc_th = 10'd200;
    logic [MS_W-1:0]  cfg_blank_ms = 16'd2, cfg_timeout_ms = 16'd20;
    logic [3:0] cfg_duty = 4'd5;
    logic clear_lockout = 1'b0;
    logic drv_en, drv_dir, drv_pwm, done;
    logic [3:0] result;
    logic [1:0] retry_cnt;
    logic [MS_W-1:0] run_ms;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    lock_act_seq #(.NUM_ILK(NUM_ILK), .CUR_W(CUR_W), .MS_W(MS_W), .CYC_PER_MS(CPM),
                   .JAM_SAMPLES(4), .MAX_RETRY(3), .PWM_PERIOD(PER)) i_lock_act_seq (
        .clk(clk), .rst(rst), .auth_pulse(auth_pulse), .move_dir(move_dir), .ilk_ok(ilk_ok),
        .low_volt(low_volt), .door_closed(door_closed), .bolt_ext(bolt_ext),
        .end_stop(end_stop), .cur_valid(cur_valid), .cur_sample(cur_sample),
        .cfg_plat_th(cfg_plat_th), .cfg_oc_th(cfg_oc_th), .cfg_blank_ms(cfg_blank_ms),
        .cfg_timeout_ms(cfg_timeout_ms), .cfg_duty(cfg_duty), .clear_lockout(clear_lockout),
        .drv_en(drv_en), .drv_dir(drv_dir), .drv_pwm(drv_pwm), .done(done),
        .result(result), .retry_cnt(retry_cnt), .run_ms(run_ms)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Profiles: 0 peak then low plateau, 1 peak then high plateau, 2 late spike.
    function automatic logic [CUR_W-1:0] prof_cur(input logic [1:0] p, input int k);
        case (p)
            2'd0: return (k < 15) ? 10'd180 : 10'd60;
            2'd1: return (k < 15) ? 10'd180 : 10'd150;
            default: return (k < 30) ? 10'd60 : 10'd250;
        endcase
    endfunction

    task automatic do_run(input logic d, input logic [1:0] prof, input int es, input int lv,
                          input logic bok, output logic [3:0] r, output logic [1:0] rt,
                          output int ms, output logic en0, output int pw, output logic dir0);
        r = 4'hF; rt = 2'd0; ms = -1; pw = 0;
        @(negedge clk); move_dir = d; auth_pulse = 1'b1;
        @(negedge clk); auth_pulse = 1'b0; en0 = drv_en; dir0 = drv_dir;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin
                r = result; rt = retry_cnt; ms = int'(run_ms);
                break;
            end
            if (k < 16 && drv_pwm) pw++;
            cur_valid  = 1'b1;
            cur_sample = prof_cur(prof, k);
            low_volt   = (lv != 0) && (k >= lv);
            if (es != 0 && k >= es) begin
                end_stop = 1'b1;
                if (bok) bolt_ext = d;
            end
            @(negedge clk);
        end
        cur_valid = 1'b0; end_stop = 1'b0; low_volt = 1'b0; cur_sample = '0;
    endtask

    typedef struct packed {
        logic       dir;
        logic [1:0] prof;
        logic [7:0] es;
        logic [7:0] lv;
        logic       bok;
        logic [3:0] res;
        logic [1:0] rty;
        logic [7:0] ms;
    } vec_t;

    // ms = 0 means run time is not checked
    localparam vec_t VECS [9] = '{
        '{1'b1, 2'd0, 8'd60, 8'd0,  1'b1, 4'd1, 2'd0, 8'd0},   // R2 success extend
        '{1'b0, 2'd0, 8'd60, 8'd0,  1'b1, 4'd1, 2'd0, 8'd0},   // R2 success retract
        '{1'b1, 2'd1, 8'd0,  8'd0,  1'b1, 4'd2, 2'd1, 8'd0},   // R6 R8 jam soft
        '{1'b1, 2'd0, 8'd50, 8'd0,  1'b0, 4'd8, 2'd1, 8'd0},   // R2 post mismatch
        '{1'b1, 2'd0, 8'd50, 8'd0,  1'b1, 4'd1, 2'd0, 8'd0},   // R8 success clears
        '{1'b0, 2'd2, 8'd0,  8'd0,  1'b1, 4'd5, 2'd0, 8'd0},   // R4 overcurrent
        '{1'b0, 2'd0, 8'd0,  8'd40, 1'b1, 4'd6, 2'd0, 8'd0},   // R3 low volt in run
        '{1'b0, 2'd0, 8'd0,  8'd0,  1'b1, 4'd4, 2'd0, 8'd20},  // R6 R7 blanking, timeout
        '{1'b0, 2'd2, 8'd30, 8'd0,  1'b1, 4'd1, 2'd0, 8'd0}    // R5 end-stop beats overcurrent
    };

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [3:0] r; logic [1:0] rt; int ms; logic en0; int pw; logic dir0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R10 reset state
        chk(drv_en == 1'b0, "R1 reset enable", drv_en, 0);
        chk(done == 1'b0 && drv_pwm == 1'b0, "R10 reset done/pwm", done, 0);
        chk(result == 4'd0, "R10 reset result", result, 0);
        chk(retry_cnt == 2'd0, "R8 reset retry", retry_cnt, 0);

        for (int i = 0; i < 9; i++) begin
            do_run(VECS[i].dir, VECS[i].prof, int'(VECS[i].es), int'(VECS[i].lv),
                   VECS[i].bok, r, rt, ms, en0, pw, dir0);
            chk(r == VECS[i].res, $sformatf("R10 vec%0d result", i), r, VECS[i].res);
            chk(rt == VECS[i].rty, $sformatf("R8 vec%0d retry", i), rt, VECS[i].rty);
            chk(en0 == 1'b1, $sformatf("R1 vec%0d enable", i), en0, 1);
            chk(dir0 == VECS[i].dir, $sformatf("R11 vec%0d dir", i), dir0, VECS[i].dir);
            chk(drv_en == 1'b0, $sformatf("R1 vec%0d enable off", i), drv_en, 0);
            if (VECS[i].ms != 0)
                chk(ms == int'(VECS[i].ms), $sformatf("R7 vec%0d run_ms", i), ms, VECS[i].ms);
            if (i == 0)
                chk(pw == 10, "R11 pwm duty", pw, 10);
        end
        // bolt is now retracted (0)

        // R2 pre mismatch: retract requested while already retracted
        do_run(1'b0, 2'd0, 0, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd7, "R2 pre mismatch", r, 7);
        chk(en0 == 1'b0, "R2 no motion", en0, 0);

        // R3 interlock refusal and low volt at auth
        ilk_ok = 3'b101;
        do_run(1'b1, 2'd0, 0, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd9 && en0 == 1'b0, "R3 interlock deny", r, 9);
        ilk_ok = '1;
        @(negedge clk); low_volt = 1'b1; move_dir = 1'b1; auth_pulse = 1'b1;
        @(negedge clk); auth_pulse = 1'b0; low_volt = 1'b0;
        chk(done && result == 4'd6 && !drv_en, "R3 low volt deny", result, 6);

        // R8 R9 three jams in a row
        do_run(1'b1, 2'd1, 0, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd2 && rt == 2'd1, "R8 jam 1 soft", r, 2);
        do_run(1'b1, 2'd1, 0, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd2 && rt == 2'd2, "R8 jam 2 soft", r, 2);
        do_run(1'b1, 2'd1, 0, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd3 && rt == 2'd3, "R8 jam 3 hard", r, 3);
        do_run(1'b1, 2'd0, 40, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd10 && en0 == 1'b0, "R9 locked out", r, 10);
        chk(rt == 2'd3, "R9 retry held", rt, 3);
        @(negedge clk); clear_lockout = 1'b1;
        @(negedge clk); clear_lockout = 1'b0;
        chk(retry_cnt == 2'd0, "R9 clear retry", retry_cnt, 0);
        do_run(1'b1, 2'd0, 40, 0, 1'b1, r, rt, ms, en0, pw, dir0);
        chk(r == 4'd1 && en0 == 1'b1, "R9 run after clear", r, 1);

        // R3 interlock lost mid-run
        @(negedge clk); move_dir = 1'b0; auth_pulse = 1'b1;
        @(negedge clk); auth_pulse = 1'b0;
        repeat (5) @(negedge clk);
        ilk_ok = 3'b011;
        @(negedge clk);
        chk(done && result == 4'd9, "R3 interlock lost", result, 9);
        @(negedge clk);
        chk(!done && !drv_en, "R10 done single cycle", done, 0);
        ilk_ok = '1;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule